// File: doc/BRIEF.md
# Multi-Resolution PWM Output Bank

This block drives twelve pulse-width-modulated pins for DC analog control, such as brightness, contrast or volume settings that an external RC filter turns into a voltage. There are three groups of four channels. Channels 0 to 3 have 7-bit resolution and channels 4 to 7 have 6-bit resolution. Both of these groups run on a strobe at one third of the system clock. Channels 10 to 13 have 8-bit resolution and advance on every system clock. The pins of channels 10 to 13 appear as `pin_hi[3:0]`.

Software writes a duty code, an enable mask and three polarity bits over a small write-only register bus. A duty code is first stored in a shadow latch. It becomes active only at the start of the next period of its group, so a pulse is never cut short. A channel whose enable is clear shows its port data bit on the pin instead of the waveform.

Top module: `pwm_bank`

## Requirements
- R1: Register map on `wr_addr`. Addresses 0–3 load channels 0–3 from `wr_data[6:0]`. Addresses 4–7 load channels 4–7 from `wr_data[5:0]`. Addresses 8–11 load channels 10–13 from `wr_data[7:0]`. Address 12 loads the enables of channels 0–7, with bit i for channel i. Address 13 loads the enables of channels 10–13 from bits 3:0. Address 14 loads polarity: bit 0 is the 7-bit group, bit 1 the 6-bit group, bit 2 the 8-bit group.
- R2: A 7-bit channel with code v and polarity 0 is HIGH for 3·v system cycles out of every 384.
- R3: A 6-bit channel with code v and polarity 0 is HIGH for 3·v system cycles out of every 192.
- R4: An 8-bit channel with code v and polarity 0 is LOW for v cycles out of every 256 and HIGH for the rest.
- R5: With code 0 and polarity 0, a 6-bit or 7-bit pin stays LOW for the whole period, and an 8-bit pin stays HIGH.
- R6: A polarity bit of 1 inverts every pin of its own group and leaves the other groups unchanged.
- R7: A channel whose enable bit is 0 shows its port data bit (`port_lo`/`port_hi`) on its pin in the same cycle.
- R8: A code write takes effect only at the next period boundary of its group. The first pulse after the write has the full length of the new code.
- R9: After reset, all codes, enables and polarity bits are 0, and every pin equals its port data bit.
- R10: The divide-by-three strobe is a single-cycle pulse. The 6-bit and 7-bit counters change only on the strobe.
- R11: A write to address 15 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| port_lo | input | 8 | Port data for channels 0–7 |
| port_hi | input | 4 | Port data for channels 10–13 |
| pin_lo | output | 8 | Pins of channels 0–7 |
| pin_hi | output | 4 | Pins of channels 10–13 |

## Verification
A code write can land in the same cycle as a period boundary, or anywhere inside a running pulse. The bench provokes this by writing a new code while a channel holds a constant level from code 0.

It then measures the first complete active run after the write. A run length equal to the new code proves the change was deferred to a boundary and not applied mid-period. Polarity writes made while all three groups are running are judged by duty counts over one whole period, group by group.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 8;
  localparam int RES_A    = 7;   // wide slow group
  localparam int RES_B    = 6;   // narrow slow group
  localparam int RES_C    = 8;   // fast group
  localparam int SLOW_DIV = 3;   // system cycles per slow step

  typedef enum logic [1:0] {
    POL_A = 2'd0,
    POL_B = 2'd1,
    POL_C = 2'd2
  } pol_bit_e;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/pwm_group.sv
module pwm_group #(
  parameter int W = 7,
  parameter int N = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic [N-1:0]        wr_sel,
  input  logic [W-1:0]        wr_val,
  output logic [W-1:0]        cnt_o,
  output logic [N-1:0][W-1:0] act_o
);
  logic [W-1:0]        cnt_q, cnt_d;
  logic [N-1:0][W-1:0] shd_q, shd_d;
  logic [N-1:0][W-1:0] act_q, act_d;
  logic                wrap;

  assign wrap = step && (cnt_q == {W{1'b1}});

  always_comb begin
    cnt_d = step ? cnt_q + 1'b1 : cnt_q;
    for (int i = 0; i < N; i++) begin
      shd_d[i] = wr_sel[i] ? wr_val : shd_q[i];
      act_d[i] = wrap ? shd_d[i] : act_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      shd_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      shd_q <= shd_d;
      act_q <= act_d;
    end
  end

  assign cnt_o = cnt_q;
  assign act_o = act_q;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NA = 4,
  parameter int NB = 4,
  parameter int NC = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [NA+NB-1:0]    port_lo,
  input  logic [NC-1:0]       port_hi,
  output logic [NA+NB-1:0]    pin_lo,
  output logic [NC-1:0]       pin_hi
);
  localparam int NLO     = NA + NB;
  localparam int BASE_B  = NA;
  localparam int BASE_C  = NA + NB;
  localparam int A_ENLO  = NA + NB + NC;
  localparam int A_ENHI  = A_ENLO + 1;
  localparam int A_POL   = A_ENLO + 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  logic tick;
  pwm_prescale #(.DIV(SLOW_DIV)) u_pre (.clk(clk), .rst_n(rst_q), .tick(tick));

  // write decode
  logic [NA-1:0] sel_a;
  logic [NB-1:0] sel_b;
  logic [NC-1:0] sel_c;
  for (genvar i = 0; i < NA; i++) begin : g_sa
    assign sel_a[i] = wr_en && (wr_addr == ADDR_W'(i));
  end
  for (genvar i = 0; i < NB; i++) begin : g_sb
    assign sel_b[i] = wr_en && (wr_addr == ADDR_W'(BASE_B + i));
  end
  for (genvar i = 0; i < NC; i++) begin : g_sc
    assign sel_c[i] = wr_en && (wr_addr == ADDR_W'(BASE_C + i));
  end

  // control registers
  logic [NLO-1:0] en_lo_q, en_lo_d;
  logic [NC-1:0]  en_hi_q, en_hi_d;
  logic [2:0]     pol_q, pol_d;

  always_comb begin
    en_lo_d = en_lo_q;
    en_hi_d = en_hi_q;
    pol_d   = pol_q;
    if (wr_en && wr_addr == ADDR_W'(A_ENLO)) en_lo_d = wr_data[NLO-1:0];
    if (wr_en && wr_addr == ADDR_W'(A_ENHI)) en_hi_d = wr_data[NC-1:0];
    if (wr_en && wr_addr == ADDR_W'(A_POL))  pol_d   = wr_data[2:0];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      en_lo_q <= '0;
      en_hi_q <= '0;
      pol_q   <= '0;
    end else begin
      en_lo_q <= en_lo_d;
      en_hi_q <= en_hi_d;
      pol_q   <= pol_d;
    end
  end

  // timebases and latches
  logic [RES_A-1:0]          cnt_a;
  logic [NA-1:0][RES_A-1:0]  act_a;
  logic [RES_B-1:0]          cnt_b;
  logic [NB-1:0][RES_B-1:0]  act_b;
  logic [RES_C-1:0]          cnt_c;
  logic [NC-1:0][RES_C-1:0]  act_c;

  pwm_group #(.W(RES_A), .N(NA)) u_ga (
    .clk(clk), .rst_n(rst_q), .step(tick), .wr_sel(sel_a),
    .wr_val(wr_data[RES_A-1:0]), .cnt_o(cnt_a), .act_o(act_a));
  pwm_group #(.W(RES_B), .N(NB)) u_gb (
    .clk(clk), .rst_n(rst_q), .step(tick), .wr_sel(sel_b),
    .wr_val(wr_data[RES_B-1:0]), .cnt_o(cnt_b), .act_o(act_b));
  pwm_group #(.W(RES_C), .N(NC)) u_gc (
    .clk(clk), .rst_n(rst_q), .step(1'b1), .wr_sel(sel_c),
    .wr_val(wr_data[RES_C-1:0]), .cnt_o(cnt_c), .act_o(act_c));

  // compare, polarity, pin select
  for (genvar i = 0; i < NA; i++) begin : g_pa
    logic wave;
    assign wave      = (cnt_a < act_a[i]) ^ pol_q[POL_A];
    assign pin_lo[i] = en_lo_q[i] ? wave : port_lo[i];
  end
  for (genvar i = 0; i < NB; i++) begin : g_pb
    logic wave;
    assign wave              = (cnt_b < act_b[i]) ^ pol_q[POL_B];
    assign pin_lo[BASE_B+i]  = en_lo_q[BASE_B+i] ? wave : port_lo[BASE_B+i];
  end
  for (genvar i = 0; i < NC; i++) begin : g_pc
    logic wave;
    assign wave      = !(cnt_c < act_c[i]) ^ pol_q[POL_C];
    assign pin_hi[i] = en_hi_q[i] ? wave : port_hi[i];
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NA = 4,
  parameter int NB = 4,
  parameter int NC = 4
) (
  input logic                       clk,
  input logic                       rst_q,
  input logic                       tick,
  input logic [6:0]                 cnt_a,
  input logic [NA-1:0][6:0]         act_a,
  input logic [5:0]                 cnt_b,
  input logic [7:0]                 cnt_c,
  input logic [NC-1:0][7:0]         act_c,
  input logic [2:0]                 pol_q,
  input logic [NA+NB-1:0]           en_lo_q,
  input logic [NC-1:0]              en_hi_q,
  input logic [NA+NB-1:0]           port_lo,
  input logic [NC-1:0]              port_hi,
  input logic [NA+NB-1:0]           pin_lo,
  input logic [NC-1:0]              pin_hi
);
  // R10
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_q)
    tick |=> !tick ##1 !tick);
  // R10
  slow_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !tick |=> $stable(cnt_a) && $stable(cnt_b));
  // R4
  fast_wrap_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cnt_c == 8'hFF) |=> (cnt_c == 8'h00));
  // R8
  slow_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !(tick && cnt_a == 7'h7F) |=> $stable(act_a));
  // R8
  fast_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cnt_c != 8'hFF) |=> $stable(act_c));

  for (genvar i = 0; i < NA; i++) begin : g_a
    // R5
    zero_low_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (en_lo_q[i] && act_a[i] == 7'd0 && !pol_q[0]) |-> !pin_lo[i]);
  end
  for (genvar i = 0; i < NC; i++) begin : g_c
    // R5
    zero_high_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (en_hi_q[i] && act_c[i] == 8'd0 && !pol_q[2]) |-> pin_hi[i]);
    // R7
    port_hi_chk: assert property (@(posedge clk) disable iff (!rst_q)
      !en_hi_q[i] |-> (pin_hi[i] == port_hi[i]));
  end
  for (genvar i = 0; i < NA + NB; i++) begin : g_lo
    // R7
    port_lo_chk: assert property (@(posedge clk) disable iff (!rst_q)
      !en_lo_q[i] |-> (pin_lo[i] == port_lo[i]));
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NA(NA), .NB(NB), .NC(NC)) u_chk (
  .clk(clk), .rst_q(rst_q), .tick(tick), .cnt_a(cnt_a), .act_a(act_a),
  .cnt_b(cnt_b), .cnt_c(cnt_c), .act_c(act_c), .pol_q(pol_q),
  .en_lo_q(en_lo_q), .en_hi_q(en_hi_q), .port_lo(port_lo),
  .port_hi(port_hi), .pin_lo(pin_lo), .pin_hi(pin_hi));

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] port_lo;
  logic [3:0] port_hi;
  logic [7:0] pin_lo;
  logic [3:0] pin_hi;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  pwm_bank dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .port_lo(port_lo), .port_hi(port_hi),
    .pin_lo(pin_lo), .pin_hi(pin_hi));

  // kind 0: high count over per cycles; kind 1: length of first run at level lvl
  typedef struct {
    int    kind;
    int    idx;
    int    per;
    int    lvl;
    int    exp;
    string req;
  } item_t;

  item_t q[$];
  bit    busy = 1'b0;

  function automatic logic pin_at(int idx);
    return (idx < 8) ? pin_lo[idx] : pin_hi[idx-8];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push(int kind, int idx, int per, int lvl, int exp, string req);
    item_t it;
    it.kind = kind; it.idx = idx; it.per = per; it.lvl = lvl;
    it.exp = exp; it.req = req;
    q.push_back(it);
    wait (q.size() == 0 && !busy);
  endtask

  task automatic duty(int idx, int per, int exp, string req);
    push(0, idx, per, 0, exp, req);
  endtask

  // monitor: pops expected items and measures the pins
  initial begin
    forever begin
      item_t it;
      int    n;
      wait (q.size() > 0);
      busy = 1'b1;
      it = q.pop_front();
      n = 0;
      if (it.kind == 0) begin
        for (int k = 0; k < it.per; k++) begin
          @(negedge clk);
          if (pin_at(it.idx)) n++;
        end
      end else begin
        for (int k = 0; k < 1200; k++) begin
          @(negedge clk);
          if (pin_at(it.idx) == 1'(it.lvl)) break;
        end
        while (pin_at(it.idx) == 1'(it.lvl) && n < 1200) begin
          n++;
          @(negedge clk);
        end
      end
      chk(n == it.exp, it.req, n, it.exp);
      busy = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  localparam int SETTLE = 800;

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    port_lo = 8'hA5; port_hi = 4'h6;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state shows port data
    chk(pin_lo == 8'hA5, "R9 pin_lo", int'(pin_lo), 8'hA5);
    chk(pin_hi == 4'h6,  "R9 pin_hi", int'(pin_hi), 4'h6);
    port_lo = 8'h3C; port_hi = 4'h9;
    @(negedge clk);
    // R7: disabled channels follow port in the same cycle
    chk(pin_lo == 8'h3C && pin_hi == 4'h9, "R7 port follow",
        int'({pin_hi, pin_lo}), 12'h93C);

    // R1: program codes and enables
    wr(0, 10); wr(1, 0); wr(2, 8'hFF);     // ch2 loads 127 (bit 7 dropped)
    wr(5, 20); wr(7, 63);
    wr(8, 50); wr(9, 0); wr(11, 255);
    wr(12, 8'hFF); wr(13, 4'hF);
    repeat (SETTLE) @(negedge clk);

    duty(0, 384, 30,  "R2 ch0 v=10");
    duty(5, 192, 60,  "R3 ch5 v=20");
    duty(8, 256, 206, "R4 ch10 v=50");
    duty(1, 384, 0,   "R5 ch1 zero low");
    duty(9, 256, 256, "R5 ch11 zero high");
    duty(2, 384, 381, "R1 ch2 7-bit mask");
    duty(7, 192, 189, "R3 ch7 v=63");
    duty(11, 256, 1,  "R4 ch13 v=255");

    // R6: invert 7-bit group only
    wr(14, 1);
    duty(0, 384, 354, "R6 ch0 inverted");
    duty(5, 192, 60,  "R6 ch5 untouched");
    duty(8, 256, 206, "R6 ch10 untouched");
    wr(14, 4);
    duty(8, 256, 50,  "R6 ch10 inverted");
    duty(0, 384, 30,  "R6 ch0 restored");
    wr(14, 0);

    // R8: new code from a constant level yields one full-length pulse
    wr(10, 200);
    push(1, 10, 0, 0, 200, "R8 ch12 first low run");
    wr(3, 40);
    push(1, 3, 0, 1, 120, "R8 ch3 first high run");
    wr(6, 1);
    push(1, 6, 0, 1, 3, "R8 ch6 first high run");

    // R7: disable ch0 only
    wr(12, 8'hFE);
    port_lo = 8'h01;
    @(negedge clk);
    chk(pin_lo[0] == 1'b1, "R7 ch0 port bit", int'(pin_lo[0]), 1);
    duty(0, 384, 384, "R7 ch0 port high");
    duty(5, 192, 60,  "R7 ch5 still pwm");
    wr(13, 4'hE);
    port_hi = 4'h0;
    @(negedge clk);
    chk(pin_hi[0] == 1'b0, "R7 ch10 port bit", int'(pin_hi[0]), 0);

    // R11: address 15 ignored
    wr(15, 8'hFF);
    repeat (SETTLE) @(negedge clk);
    duty(5, 192, 60,  "R11 ch5 unchanged");
    duty(9, 256, 256, "R11 ch11 unchanged");
    duty(1, 384, 0,   "R11 ch1 unchanged");
    chk(pin_lo[0] == 1'b1, "R11 ch0 enable unchanged", int'(pin_lo[0]), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule